// File: doc/BRIEF.md
# Sector-Locked PWM Sample Scheduler

This block turns a frequency command into a schedule of PWM sampling instants for a twelve-sector modulator. A phase accumulator advances by the commanded increment on every enabled clock. Its angle is split into twelve equal sectors of 30 degrees, and each sector is cut into S equal sample slots. S is a power of two that depends on the command frequency. A strobe marks the first enabled step inside every new slot. The first slot of each sector opens on the step that enters the sector, so the sample grid always restarts at the sector edge and every fundamental cycle holds 12·S samples.

S comes from a four-level frequency band. The band follows the increment with a hysteresis margin and moves at most one level per clock. Two band-to-S tables can be selected: a base table (4, 2, 1, 1) and a fine table (8, 4, 2, 1). At the top band one sample falls on each sector edge, which gives twelve-step operation. A new S requested mid-sector is applied only at the next sector start. The sample period in enabled ticks is recomputed at that same instant. The accumulated angle is also brought out for the downstream vector arithmetic.

Top module: `sector_sample_sched`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block clears angle, sector, sample_idx, sample_stb and sample_period to zero, sets the band to 0, and arms a pending sector start.
- R2: On each edge with ce high, angle becomes (angle + phase_inc) mod 2^32. With ce low, angle, sector, sample_idx and sample_period hold, and sample_stb is 0 in the next cycle.
- R3: sector equals floor(angle·12 / 2^32) and always lies in 0..11.
- R4: sample_idx equals floor(r·S / 2^32), where r = (angle·12) mod 2^32 and S is the active samples-per-sector count. It always lies in 0..S-1.
- R5: sample_stb is high for exactly the cycle after an enabled step that either enters a new sector (or is the first enabled step after reset) or changes sample_idx. Every sector change is strobed.
- R6: Requested S depends on tbl_sel and the band. tbl_sel=0 maps bands 0,1,2,3 to 4,2,1,1. tbl_sel=1 maps them to 8,4,2,1.
- R7: The band rises from b to b+1 when phase_inc > thr[b] + hyst. It falls from b to b-1 when phase_inc + hyst < thr[b-1]. Here thr[0..2] = thr_lo, thr_mid, thr_hi. The band moves by at most one level per clock.
- R8: The active S is loaded from the requested S only at a sector start. Between sector starts it does not change.
- R9: At each sector start, sample_period is loaded with floor(2^32 / (12·S·phase_inc)), where S is the newly active count. When phase_inc is 0, it is loaded with all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Step enable for the phase accumulator |
| phase_inc | input | 32 | Angle step per enabled tick (frequency command) |
| tbl_sel | input | 1 | Band table: 0 base, 1 fine |
| thr_lo | input | 32 | Band 0/1 boundary, in increment units |
| thr_mid | input | 32 | Band 1/2 boundary |
| thr_hi | input | 32 | Band 2/3 boundary |
| hyst | input | 32 | Hysteresis margin, in increment units |
| angle | output | 32 | Accumulated reference angle |
| sector | output | 4 | Sector index 0..11 |
| sample_idx | output | 3 | Sample slot within the sector |
| sample_stb | output | 1 | One-cycle sampling strobe |
| sample_period | output | 32 | Enabled ticks per sample slot |

## Verification
The single-step band assertion assumes the thresholds rise strictly (thr_lo < thr_mid < thr_hi) and that hyst is smaller than half of any threshold gap. The stimulus holds the thresholds and margin at fixed values that meet these conditions, and it changes only phase_inc, tbl_sel and ce. Increments stay far below one sample slot per step, so a changed sample_idx always means the next slot rather than a skipped one. The zero-increment period case is reached only through the pending start that follows reset.

// File: rtl/sched_pkg.sv
// Shared widths and the band-to-samples mapping for the sector scheduler.
// Assumes twelve sectors and at most eight samples per sector.
package sched_pkg;
    localparam int SECTORS = 12;
    localparam int SEC_W   = 4;   // holds 0..11
    localparam int IDX_W   = 3;   // holds 0..7
    localparam int LOG_W   = 2;   // log2 of samples per sector, 0..3
    localparam int BAND_W  = 2;   // four frequency bands

    typedef logic [BAND_W-1:0] band_t;
    typedef logic [LOG_W-1:0]  slog_t;

    // Map table select and band to log2(samples per sector)
    function automatic slog_t sps_log_of(input logic fine, input band_t b);
        slog_t r;
        if (fine) begin
            r = slog_t'(2'd3 - b);              // 8,4,2,1
        end else begin
            case (b)
                2'd0:    r = 2'd2;              // 4
                2'd1:    r = 2'd1;              // 2
                default: r = 2'd0;              // 1
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/sched_band.sv
// Frequency band tracker with hysteresis. It moves at most one level
// per clock. Assumes the thresholds rise strictly.
module sched_band
    import sched_pkg::*;
#(
    parameter int PH_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] inc,
    input  logic [PH_W-1:0] thr_a,
    input  logic [PH_W-1:0] thr_b,
    input  logic [PH_W-1:0] thr_c,
    input  logic [PH_W-1:0] margin,
    output band_t           band_q
);
    logic [PH_W-1:0] up_thr, dn_thr;
    logic            up_ok, dn_ok;

    // Pick the thresholds that bound the current band
    always_comb begin
        case (band_q)
            2'd0:    begin up_thr = thr_a; dn_thr = thr_a; end
            2'd1:    begin up_thr = thr_b; dn_thr = thr_a; end
            2'd2:    begin up_thr = thr_c; dn_thr = thr_b; end
            default: begin up_thr = thr_c; dn_thr = thr_c; end
        endcase
        up_ok = (band_q != 2'd3) &&
                ({1'b0, inc} > ({1'b0, up_thr} + {1'b0, margin}));
        dn_ok = (band_q != 2'd0) &&
                (({1'b0, inc} + {1'b0, margin}) < {1'b0, dn_thr});
    end

    // Step the band one level toward the command
    always_ff @(posedge clk) begin
        if (!rst_n)     band_q <= '0;
        else if (up_ok) band_q <= band_q + 2'd1;
        else if (dn_ok) band_q <= band_q - 2'd1;
    end

    // R7
    band_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (band_q == $past(band_q)) || (band_q == $past(band_q) + 2'd1) ||
        (band_q + 2'd1 == $past(band_q)));
endmodule

// File: rtl/sched_phase.sv
// Phase accumulator. It also gives the sector and the in-sector residual
// of the next angle. Assumes a power-of-two angle range of 2^PH_W.
module sched_phase
    import sched_pkg::*;
#(
    parameter int PH_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [PH_W-1:0]  inc,
    output logic [PH_W-1:0]  acc_q,
    output logic [SEC_W-1:0] sec_nx,
    output logic [PH_W-1:0]  res_nx
);
    localparam int PW = PH_W + SEC_W;
    logic [PH_W-1:0] acc_nx;

    // Scale the next angle by twelve; the top bits give the sector
    always_comb begin
        acc_nx = acc_q + inc;
        sec_nx = SEC_W'(({{SEC_W{1'b0}}, acc_nx} * PW'(SECTORS)) >> PH_W);
        res_nx = PH_W'({{SEC_W{1'b0}}, acc_nx} * PW'(SECTORS));
    end

    // Advance the angle on enabled ticks
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_q <= '0;
        else if (ce) acc_q <= acc_nx;
    end

    // R2
    angle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(acc_q));
endmodule

// File: rtl/sched_period.sv
// Combinational sample-period divider: 2^PH_W / (12 * 2^slog * inc).
// A zero increment or a quotient too wide for PER_W gives all ones.
module sched_period
    import sched_pkg::*;
#(
    parameter int PH_W  = 32,
    parameter int PER_W = 32
) (
    input  logic [PH_W-1:0]  inc,
    input  slog_t            slog,
    output logic [PER_W-1:0] period
);
    localparam int DW = PH_W + SEC_W;
    logic [DW-1:0] num, den, quo;

    // One wide divide, used only at sector starts
    always_comb begin
        num = DW'(1) << (PH_W - int'(slog));
        den = (inc == '0) ? DW'(1) : ({{SEC_W{1'b0}}, inc} * DW'(SECTORS));
        quo = num / den;
        if (inc == '0 || quo > DW'({PER_W{1'b1}})) period = '1;
        else                                       period = PER_W'(quo);
    end
endmodule

// File: rtl/sector_sample_sched.sv
// Sector-locked PWM sample scheduler. It issues sampling strobes on a
// grid that restarts at every 30-degree sector edge, with a per-band
// sample count. Assumes ce paces the modulator tick and the thresholds
// rise strictly.
module sector_sample_sched
    import sched_pkg::*;
#(
    parameter int PH_W  = 32,
    parameter int PER_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [PH_W-1:0]   phase_inc,
    input  logic              tbl_sel,
    input  logic [PH_W-1:0]   thr_lo,
    input  logic [PH_W-1:0]   thr_mid,
    input  logic [PH_W-1:0]   thr_hi,
    input  logic [PH_W-1:0]   hyst,
    output logic [PH_W-1:0]   angle,
    output logic [SEC_W-1:0]  sector,
    output logic [IDX_W-1:0]  sample_idx,
    output logic              sample_stb,
    output logic [PER_W-1:0]  sample_period
);
    band_t            band;
    slog_t            req_log, sps_log_q, sps_use;
    logic [SEC_W-1:0] sec_nx;
    logic [PH_W-1:0]  res_nx;
    logic [PER_W-1:0] per_nx;
    logic [IDX_W-1:0] idx_nx;
    logic             pend_q, sec_start, stb_nx;

    sched_band #(.PH_W(PH_W)) u_band (
        .clk(clk), .rst_n(rst_n), .inc(phase_inc),
        .thr_a(thr_lo), .thr_b(thr_mid), .thr_c(thr_hi),
        .margin(hyst), .band_q(band)
    );

    sched_phase #(.PH_W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .ce(ce), .inc(phase_inc),
        .acc_q(angle), .sec_nx(sec_nx), .res_nx(res_nx)
    );

    sched_period #(.PH_W(PH_W), .PER_W(PER_W)) u_period (
        .inc(phase_inc), .slog(req_log), .period(per_nx)
    );

    // Decide sector start, the grid in force and the next slot
    always_comb begin
        req_log   = sps_log_of(tbl_sel, band);
        sec_start = ce && (pend_q || (sec_nx != sector));
        sps_use   = sec_start ? req_log : sps_log_q;
        idx_nx    = IDX_W'(({{IDX_W{1'b0}}, res_nx} << sps_use) >> PH_W);
        stb_nx    = ce && (sec_start || (idx_nx != sample_idx));
    end

    // Register the schedule; the grid and period change only at sector starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sector        <= '0;
            sample_idx    <= '0;
            sample_stb    <= 1'b0;
            sample_period <= '0;
            sps_log_q     <= '0;
            pend_q        <= 1'b1;
        end else begin
            sample_stb <= stb_nx;
            if (ce) begin
                sector     <= sec_nx;
                sample_idx <= idx_nx;
                pend_q     <= 1'b0;
            end
            if (sec_start) begin
                sps_log_q     <= req_log;
                sample_period <= per_nx;
            end
        end
    end

    // R3
    sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sector < SEC_W'(SECTORS));

    // R4
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, sample_idx} < ((IDX_W+1)'(1) << sps_log_q));

    // R5
    strobe_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(ce));

    // R5
    sector_edge_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sector) |-> sample_stb);

    // R8
    grid_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sps_log_q) |-> ($past(pend_q) || !$stable(sector)));

    // R9
    period_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_period) |-> ($past(pend_q) || !$stable(sector)));
endmodule

// File: tb/sim_sector_sample_sched.sv
// Bench: a behavioural model run on integers, compared on every clock.
module sim_sector_sample_sched;
    localparam int CLK_NS = 10;
    localparam longint FULL = 64'h1_0000_0000;

    logic        clk = 1'b0, rst_n = 1'b0, ce = 1'b0, tbl_sel = 1'b0;
    logic [31:0] phase_inc = '0, thr_lo = '0, thr_mid = '0, thr_hi = '0, hyst = '0;
    logic [31:0] angle, sample_period;
    logic [3:0]  sector;
    logic [2:0]  sample_idx;
    logic        sample_stb;

    int checks = 0, errors = 0;
    bit done = 0;

    longint m_acc, m_per;
    int     m_sec, m_idx, m_sps, m_band;
    bit     m_stb, m_pend;

    sector_sample_sched u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .phase_inc(phase_inc),
        .tbl_sel(tbl_sel), .thr_lo(thr_lo), .thr_mid(thr_mid), .thr_hi(thr_hi),
        .hyst(hyst), .angle(angle), .sector(sector), .sample_idx(sample_idx),
        .sample_stb(sample_stb), .sample_period(sample_period)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model of one rising edge, from the requirement text
    task automatic model_edge();
        longint th[3];
        longint p, res;
        int     req, sec;
        bit     start;
        if (!rst_n) begin
            m_acc = 0; m_sec = 0; m_idx = 0; m_sps = 1; m_per = 0;
            m_stb = 0; m_pend = 1; m_band = 0;
            return;
        end
        th[0] = thr_lo; th[1] = thr_mid; th[2] = thr_hi;
        if (tbl_sel) req = 8 >> m_band;
        else         req = (m_band == 0) ? 4 : (m_band == 1) ? 2 : 1;
        if (ce) begin
            m_acc = (m_acc + phase_inc) % FULL;
            p     = m_acc * 12;
            sec   = int'(p / FULL);
            res   = p % FULL;
            start = m_pend || (sec != m_sec);
            if (start) begin
                m_sps = req;
                m_per = (phase_inc == 0) ? 64'hFFFF_FFFF :
                        FULL / (12 * longint'(m_sps) * longint'(phase_inc));
            end
            begin
                int nidx;
                nidx  = int'((res * m_sps) / FULL);
                m_stb = start || (nidx != m_idx);
                m_idx = nidx;
            end
            m_sec  = sec;
            m_pend = 0;
        end else begin
            m_stb = 0;
        end
        if (m_band < 3 && longint'(phase_inc) > th[m_band] + longint'(hyst))
            m_band++;
        else if (m_band > 0 && longint'(phase_inc) + longint'(hyst) < th[m_band-1])
            m_band--;
    endtask

    task automatic compare_all();
        chk("R2 angle", angle, m_acc);
        chk("R3 sector", sector, m_sec);
        chk("R4 R6 R7 R8 sample_idx", sample_idx, m_idx);
        chk("R5 sample_stb", sample_stb, m_stb);
        chk("R9 sample_period", sample_period, m_per);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        thr_lo = 32'd6_000_000; thr_mid = 32'd12_000_000; thr_hi = 32'd20_000_000;
        hyst = 32'd500_000;
        step(3);
        // R1 reset state
        chk("R1 reset angle", angle, 0);
        chk("R1 reset sector", sector, 0);
        chk("R1 reset sample_idx", sample_idx, 0);
        chk("R1 reset sample_stb", sample_stb, 0);
        chk("R1 reset sample_period", sample_period, 0);

        rst_n = 1'b1; phase_inc = 32'd4_000_000; ce = 1'b1;
        step(1500);                                   // base table, band 0
        for (int i = 0; i < 200; i++) begin           // R2 gated steps
            ce = i[0];
            step(1);
        end
        ce = 1'b1;
        phase_inc = 32'd9_000_000;  step(600);        // R8 mid-sector change
        phase_inc = 32'd16_000_000; step(600);        // band 2, twelve-step
        tbl_sel = 1'b1;             step(600);        // R6 fine table
        phase_inc = 32'd25_000_000; step(400);        // band 3
        phase_inc = 32'd4_000_000;  step(400);        // falls to band 0
        phase_inc = 32'd6_300_000;  step(500);        // R7 inside margin
        phase_inc = 32'd6_600_000;  step(500);        // R7 beyond margin
        phase_inc = 32'd11_800_000; step(300);
        phase_inc = 32'd5_400_000;  step(400);        // R7 falls below margin

        // R9 zero increment at the pending start after reset
        rst_n = 1'b0; step(2);
        rst_n = 1'b1; phase_inc = 32'd0;
        step(1);
        chk("R5 first strobe after reset", sample_stb, 1);
        chk("R9 zero increment period", sample_period, 64'hFFFF_FFFF);
        step(3);
        chk("R5 no strobe without new slot", sample_stb, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule